// File: doc/BRIEF.md
# Two-Input Event Fragment Merger

This block joins event fragments arriving on two independent 64-bit readout links into a single output stream. Two small data sources can then share one downstream link. Each input word carries a control/data qualifier. The qualifier marks framing words (begin-of-event and end-of-event) apart from payload. Each input is buffered in its own FIFO.

The merger drains one input at a time, and always drains a whole fragment before it moves on. For every event it sends the fragment from port 0 first and the fragment from port 1 second. It does not take up the next event until both fragments have gone out. When it forwards the port-1 header, it compares that header's trigger number with the one captured from the port-0 header of the same event. A difference sets a sticky flag, and forwarding carries on regardless.

The inputs have no ready signal. Each input gets a hold (backpressure) output instead, which rises while that FIFO has fewer than 16 free entries. A sender that sees hold may still deliver the words it already has in flight, and those words are stored. The output follows valid/ready rules. A word is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a presented word stays fixed until it is taken.

Top module: `frag_merge2`

## Requirements
- R1: After reset `out_valid`, `in0_hold`, `in1_hold` and `trig_mismatch` are all 0.
- R2: A begin-of-event word has ctrl=1 and data[63:60]=4'h5. Its trigger number sits in data[55:32]. An end-of-event word has ctrl=1 and data[63:60]=4'hA. Payload words have ctrl=0.
- R3: For each event, the complete port-0 fragment, up to and including its end-of-event word, leaves before any port-1 word. This holds even when the port-1 data arrived first.
- R4: After the port-1 end-of-event word, the block returns to port 0. Successive events therefore come out as port-0 and port-1 fragment pairs, in arrival order.
- R5: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_ctrl` hold their values.
- R6: `inN_hold` is 1 exactly while FIFO N has fewer than 16 free entries. Words written while hold is high are still stored and forwarded.
- R7: If the trigger numbers of the two headers of one event differ, `trig_mismatch` becomes 1 and stays 1 until reset. Later fragments are still forwarded.
- R8: Words pass through with data and ctrl unchanged. A payload word (ctrl=0) whose top nibble is 4'hA does not end a fragment.
- R9: When the two headers of an event carry equal trigger numbers, `trig_mismatch` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Port 0 word strobe |
| in0_ctrl | input | 1 | Port 0 control/data qualifier (1 = framing) |
| in0_data | input | 64 | Port 0 word |
| in0_hold | output | 1 | Port 0 backpressure |
| in1_valid | input | 1 | Port 1 word strobe |
| in1_ctrl | input | 1 | Port 1 control/data qualifier |
| in1_data | input | 64 | Port 1 word |
| in1_hold | output | 1 | Port 1 backpressure |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_ctrl | output | 1 | Output qualifier |
| out_data | output | 64 | Output word |
| trig_mismatch | output | 1 | Sticky trigger-number mismatch flag |

## Verification
A word written at an input edge sits in the FIFO after that edge. It can reach the output register at the next edge, so it appears on `out_valid`/`out_data` one cycle after it was accepted, provided the output is empty or being taken. Hold follows the FIFO fill, and the fill changes at the same edge as each write. The bench therefore reads hold one cycle after its last push. The mismatch flag rises at the edge that loads the port-1 header into the output, and it is checked once the stream has drained. Every stimulus is applied just after a rising edge. A monitor records each transfer at the falling edge, when valid and ready are stable, and the bench compares the recorded stream with an expected list.

// File: rtl/frag_merge_pkg.sv
package frag_merge_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned TRIG_W   = 24;
  localparam int unsigned NPORTS   = 2;
  localparam logic [3:0]  TAG_BOE  = 4'h5;
  localparam logic [3:0]  TAG_EOE  = 4'hA;

  typedef struct packed {
    logic              ctrl;
    logic [WORD_W-1:0] data;
  } link_word_t;

  function automatic logic is_boe(input link_word_t w);
    return w.ctrl && (w.data[WORD_W-1 -: 4] == TAG_BOE);
  endfunction

  function automatic logic is_eoe(input link_word_t w);
    return w.ctrl && (w.data[WORD_W-1 -: 4] == TAG_EOE);
  endfunction

  function automatic logic [TRIG_W-1:0] trig_of(input link_word_t w);
    return w.data[55:32];
  endfunction
endpackage

// File: rtl/fm_fifo.sv
module fm_fifo
  import frag_merge_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned MARGIN = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  link_word_t wr_word,
  input  logic       rd_en,
  output link_word_t rd_word,
  output logic       empty,
  output logic       hold,
  output logic [CW-1:0] level
);
  link_word_t        mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic              do_wr, do_rd;

  assign do_wr = wr_en && (cnt != CW'(DEPTH));
  assign do_rd = rd_en && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_word = mem[rptr];
  assign empty   = (cnt == '0);
  assign hold    = (CW'(DEPTH) - cnt) < CW'(MARGIN);
  assign level   = cnt;
endmodule

// File: rtl/fm_sequencer.sv
module fm_sequencer
  import frag_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] empty,
  input  link_word_t        head [NPORTS],
  input  logic              take,
  output logic [NPORTS-1:0] pop,
  output link_word_t        sel_word,
  output logic              sel_valid,
  output logic              mismatch
);
  logic              cur;
  logic [TRIG_W-1:0] trig_first;
  logic              err_q;
  link_word_t        w;

  assign w         = head[cur];
  assign sel_valid = !empty[cur] && take;
  assign sel_word  = w;

  always_comb begin
    pop = '0;
    pop[cur] = sel_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= 1'b0;
      trig_first <= '0;
      err_q      <= 1'b0;
    end else if (sel_valid) begin
      if (is_eoe(w)) cur <= ~cur;
      if (is_boe(w)) begin
        if (cur == 1'b0) trig_first <= trig_of(w);
        else if (trig_of(w) != trig_first) err_q <= 1'b1;
      end
    end
  end

  assign mismatch = err_q;
endmodule

// File: rtl/fm_out_slice.sv
module fm_out_slice
  import frag_merge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  link_word_t load_word,
  output logic       take,
  output logic       o_valid,
  input  logic       o_ready,
  output link_word_t o_word
);
  logic       v_q;
  link_word_t w_q;

  assign take = !v_q || o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      w_q <= '0;
    end else if (take) begin
      v_q <= load;
      if (load) w_q <= load_word;
    end
  end

  assign o_valid = v_q;
  assign o_word  = w_q;
endmodule

// File: rtl/frag_merge2.sv
module frag_merge2
  import frag_merge_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned MARGIN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in0_valid,
  input  logic        in0_ctrl,
  input  logic [63:0] in0_data,
  output logic        in0_hold,
  input  logic        in1_valid,
  input  logic        in1_ctrl,
  input  logic [63:0] in1_data,
  output logic        in1_hold,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_ctrl,
  output logic [63:0] out_data,
  output logic        trig_mismatch
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic              wr   [NPORTS];
  link_word_t        win  [NPORTS];
  link_word_t        head [NPORTS];
  logic [NPORTS-1:0] empty, hold, pop;
  logic [CW-1:0]     fill [NPORTS];
  link_word_t        sel_word, o_word;
  logic              sel_valid, take;

  assign wr[0]  = in0_valid;
  assign wr[1]  = in1_valid;
  assign win[0] = '{ctrl: in0_ctrl, data: in0_data};
  assign win[1] = '{ctrl: in1_ctrl, data: in1_data};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    fm_fifo #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr[p]), .wr_word(win[p]),
      .rd_en(pop[p]), .rd_word(head[p]),
      .empty(empty[p]), .hold(hold[p]), .level(fill[p])
    );
  end

  fm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .empty(empty), .head(head), .take(take),
    .pop(pop), .sel_word(sel_word), .sel_valid(sel_valid),
    .mismatch(trig_mismatch)
  );

  fm_out_slice u_out (
    .clk(clk), .rst_n(rst_n), .load(sel_valid), .load_word(sel_word),
    .take(take), .o_valid(out_valid), .o_ready(out_ready), .o_word(o_word)
  );

  assign in0_hold = hold[0];
  assign in1_hold = hold[1];
  assign out_ctrl = o_word.ctrl;
  assign out_data = o_word.data;
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_ctrl,
  input logic [63:0]   out_data,
  input logic          trig_mismatch,
  input logic [1:0]    pop,
  input logic [CW-1:0] fill0,
  input logic [CW-1:0] fill1
);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_mismatch |=> trig_mismatch);

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill0 <= CW'(DEPTH)) && (fill1 <= CW'(DEPTH)));
endmodule

bind frag_merge2 fm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_ctrl(out_ctrl), .out_data(out_data), .trig_mismatch(trig_mismatch),
  .pop(pop), .fill0(fill[0]), .fill1(fill[1])
);

// File: tb/frag_merge2_test.sv
module frag_merge2_test;
  logic        clk = 0, rst_n = 0;
  logic        in0_valid = 0, in0_ctrl = 0, in1_valid = 0, in1_ctrl = 0;
  logic [63:0] in0_data = '0, in1_data = '0;
  logic        in0_hold, in1_hold, out_valid, out_ctrl, trig_mismatch;
  logic        out_ready = 0;
  logic [63:0] out_data;

  int checks = 0, failures = 0;
  logic [64:0] cap [0:511];
  logic [64:0] exp_q [0:511];
  int ncap = 0, nexp = 0;

  always #2.5 clk = ~clk;

  frag_merge2 uut (.*);

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && ncap < 512) begin
      cap[ncap] = {out_ctrl, out_data};
      ncap++;
    end

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [64:0] hdr(input logic [23:0] t, input logic [7:0] tag);
    return {1'b1, 4'h5, 4'h0, t, tag, 24'h0};
  endfunction
  function automatic logic [64:0] trl(input logic [7:0] tag);
    return {1'b1, 4'hA, 52'h0, tag};
  endfunction
  function automatic logic [64:0] pay(input logic [7:0] tag, input int i);
    return {1'b0, 4'h3, 28'h0, tag, 8'(i), 16'h0};
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic push(input int port, input logic [64:0] w);
    if (port == 0) begin in0_valid = 1; {in0_ctrl, in0_data} = w; end
    else           begin in1_valid = 1; {in1_ctrl, in1_data} = w; end
    tick();
    in0_valid = 0; in1_valid = 0;
  endtask

  task automatic add_exp(input logic [64:0] w); exp_q[nexp] = w; nexp++; endtask

  task automatic frag(input int port, input logic [23:0] t, input logic [7:0] tag, input int npay);
    push(port, hdr(t, tag));
    for (int i = 0; i < npay; i++) push(port, pay(tag, i));
    push(port, trl(tag));
  endtask

  task automatic do_reset();
    rst_n = 0; out_ready = 0; in0_valid = 0; in1_valid = 0;
    repeat (3) tick();
    rst_n = 1; ncap = 0; nexp = 0;
    tick();
  endtask

  task automatic drain_and_compare(input string req);
    out_ready = 1;
    repeat (200) tick();
    check({req, " count"}, 65'(ncap), 65'(nexp));
    for (int i = 0; i < nexp; i++) check(req, cap[i], exp_q[i]);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out_valid", 65'(out_valid), 65'd0);
    check("R1 holds", 65'({in0_hold, in1_hold}), 65'd0);
    check("R1 mismatch", 65'(trig_mismatch), 65'd0);
  endtask

  task automatic t_order();
    do_reset();
    frag(1, 24'h10, 8'hB1, 3);
    frag(0, 24'h10, 8'hA1, 2);
    frag(0, 24'h11, 8'hA2, 1);
    frag(1, 24'h11, 8'hB2, 0);
    add_exp(hdr(24'h10, 8'hA1)); add_exp(pay(8'hA1, 0)); add_exp(pay(8'hA1, 1)); add_exp(trl(8'hA1));
    add_exp(hdr(24'h10, 8'hB1)); for (int i = 0; i < 3; i++) add_exp(pay(8'hB1, i)); add_exp(trl(8'hB1));
    add_exp(hdr(24'h11, 8'hA2)); add_exp(pay(8'hA2, 0)); add_exp(trl(8'hA2));
    add_exp(hdr(24'h11, 8'hB2)); add_exp(trl(8'hB2));
    drain_and_compare("R3 R4 R2 order");
    check("R9 match keeps flag low", 65'(trig_mismatch), 65'd0);
  endtask

  task automatic t_stall();
    logic [64:0] w;
    do_reset();
    frag(0, 24'h22, 8'hC1, 1);
    tick();
    check("R5 valid under stall", 65'(out_valid), 65'd1);
    w = {out_ctrl, out_data};
    check("R5 head word", w, hdr(24'h22, 8'hC1));
    repeat (5) tick();
    check("R5 stable", {out_ctrl, out_data}, w);
    frag(1, 24'h22, 8'hD1, 0);
    add_exp(hdr(24'h22, 8'hC1)); add_exp(pay(8'hC1, 0)); add_exp(trl(8'hC1));
    add_exp(hdr(24'h22, 8'hD1)); add_exp(trl(8'hD1));
    drain_and_compare("R5 after stall");
  endtask

  task automatic t_backpressure();
    do_reset();
    push(0, hdr(24'h33, 8'hE1));
    for (int i = 0; i < 48; i++) push(0, pay(8'hE1, i));
    check("R6 hold low at 16 free", 65'(in0_hold), 65'd0);
    push(0, pay(8'hE1, 48));
    check("R6 hold high at 15 free", 65'(in0_hold), 65'd1);
    check("R6 other port unaffected", 65'(in1_hold), 65'd0);
    push(0, pay(8'hE1, 49));
    push(0, pay(8'hE1, 50));
    push(0, trl(8'hE1));
    add_exp(hdr(24'h33, 8'hE1));
    for (int i = 0; i < 51; i++) add_exp(pay(8'hE1, i));
    add_exp(trl(8'hE1));
    drain_and_compare("R6 in-flight words kept");
    check("R6 hold released", 65'(in0_hold), 65'd0);
  endtask

  task automatic t_mismatch();
    do_reset();
    frag(0, 24'h000007, 8'hF1, 1);
    frag(1, 24'h800007, 8'hF2, 1);
    frag(0, 24'h000008, 8'hF3, 0);
    frag(1, 24'h000008, 8'hF4, 0);
    add_exp(hdr(24'h000007, 8'hF1)); add_exp(pay(8'hF1, 0)); add_exp(trl(8'hF1));
    add_exp(hdr(24'h800007, 8'hF2)); add_exp(pay(8'hF2, 0)); add_exp(trl(8'hF2));
    add_exp(hdr(24'h000008, 8'hF3)); add_exp(trl(8'hF3));
    add_exp(hdr(24'h000008, 8'hF4)); add_exp(trl(8'hF4));
    drain_and_compare("R7 forwarding continues");
    check("R7 sticky flag", 65'(trig_mismatch), 65'd1);
  endtask

  task automatic t_fake_trailer();
    logic [64:0] fake;
    do_reset();
    fake = {1'b0, 4'hA, 60'h123};
    push(0, hdr(24'h44, 8'h91));
    push(0, fake);
    push(0, trl(8'h91));
    push(1, hdr(24'h44, 8'h92));
    push(1, trl(8'h92));
    add_exp(hdr(24'h44, 8'h91)); add_exp(fake); add_exp(trl(8'h91));
    add_exp(hdr(24'h44, 8'h92)); add_exp(trl(8'h92));
    drain_and_compare("R8 payload 0xA not trailer");
    check("R9 flag low", 65'(trig_mismatch), 65'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_stall();
    t_backpressure();
    t_mismatch();
    t_fake_trailer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule